// File: doc/BRIEF.md
# Handshake-Ordered Four-Rail Power Sequencer

This controller switches four supply rails on and off in a fixed order, with no programmable delays. Gate A comes up first, then B, C and D. Shutdown runs D, C, B, A. The controller does not time each step. It enables one gate and waits until that gate's switch reports that it has finished ramping. Only then does it move to the next gate. Shutdown works the same way, using the fully-off status.

Start-up begins only after two things have held for a qualification window (default 10 ms at 50 MHz): all four rail-good inputs are high, and the active-low enable is low. A stabilization timer (default 160 ms) starts once gate D reports fully on. When it expires, the reset-done output goes high.

A rail-good drop is a fault only if it lasts longer than a glitch window (default 30 µs). A fault drops every gate in the same cycle. A low level on the system-reset input does the same. After either event the controller starts over and must requalify before it can power up again.

Top module: `rail_handshake_seq`

## Requirements
- R1: While reset is held, and in the first cycles after it is released with enable inactive, all four gate enables are 0 and resetDone is 0.
- R2: Turn-on starts only after every rail-good input is high and enableN is low for QUAL_CYCLES consecutive cycles. Before that, gateEn stays 4'b0000. After it, gateEn becomes 4'b0001 (bit 0 is gate A, bit 3 is gate D).
- R3: Gates are enabled cumulatively in the order A, B, C, D. Gate k+1 is enabled only after gateOnDone[k] has been seen high. While it is low, the enable pattern holds.
- R4: resetDone stays low until STAB_CYCLES cycles after gateOnDone[3] is seen with all four gates enabled. It then goes high.
- R5: When enableN goes high after a full power-up, resetDone falls within one cycle. Gates are then released in the order D, C, B, A. Gate k-1 is released only after gateOffDone[k] is seen high.
- R6: If enableN goes high during turn-on, the highest gate that is enabled is released at once. Shutdown then continues downward in reverse order.
- R7: A rail-good low lasting fewer than GLITCH_CYCLES consecutive cycles has no effect on gateEn or resetDone.
- R8: A rail-good low lasting GLITCH_CYCLES cycles or more clears all four gate enables in the same cycle and forces resetDone low. If enable is still active, the controller then requalifies and powers up again.
- R9: While sysResetN is low, all gate enables and resetDone are 0. After release, a new power-up needs a full qualification window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| railGood | input | 4 | Rail-good level per rail, bit 0 = A |
| enableN | input | 1 | Active-low sequencing enable |
| gateOnDone | input | 4 | Gate reports fully on, bit 0 = A |
| gateOffDone | input | 4 | Gate reports fully off, bit 0 = A |
| sysResetN | input | 1 | Active-low immediate latch-off of all gates |
| gateEn | output | 4 | Gate enables, bit 0 = A |
| resetDone | output | 1 | High once the sequence is complete and stable |

## Verification
The hardest case to reach is an enable withdrawal that lands between two handshakes. Here gate B has been enabled but has not reported fully on, and gate B also does not yet report fully off. The bench drives the gate status inputs by hand for this case. It holds B's off-status low at the moment enable is withdrawn, then checks that gate A stays on until B's off-status arrives. Full power-ups for the fault and system-reset cases use a simple gate model in the bench that answers each enable after a few cycles.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UP, S_STAB, S_RUN, S_DOWN, S_FAULT
  } seqState_t;

  // strobes from control to datapath timers
  typedef struct packed {
    logic qualArm;
    logic stabRun;
  } seqStrobe_t;
endpackage

// File: rtl/rail_seq_datapath.sv
module rail_seq_datapath
  import rail_seq_pkg::*;
#(
  parameter int NRAIL         = 4,
  parameter int QUAL_CYCLES   = 500000,
  parameter int STAB_CYCLES   = 8000000,
  parameter int GLITCH_CYCLES = 1500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NRAIL-1:0] railGood,
  input  logic             enableN,
  input  logic             sysResetN,
  input  seqStrobe_t       strobe,
  output logic             allRailOk,
  output logic             qualDone,
  output logic             stabDone
);
  localparam int GW = $clog2(GLITCH_CYCLES + 1);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int SW = $clog2(STAB_CYCLES + 1);

  logic [NRAIL-1:0] railFilt;
  logic [QW-1:0]    qualCnt;
  logic [SW-1:0]    stabCnt;

  // per-rail low-duration filter
  for (genvar i = 0; i < NRAIL; i++) begin : g_filt
    logic [GW-1:0] lowCnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lowCnt      <= '0;
        railFilt[i] <= 1'b0;
      end else if (railGood[i]) begin
        lowCnt      <= '0;
        railFilt[i] <= 1'b1;
      end else if (lowCnt == GW'(GLITCH_CYCLES - 1)) begin
        railFilt[i] <= 1'b0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end

    p_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(railFilt[i]) |-> $past(!railGood[i]));
  end

  assign allRailOk = &railFilt;

  // qualification window: rails good and enable active, uninterrupted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      qualCnt <= '0;
    else if (!strobe.qualArm || !allRailOk || enableN || !sysResetN)
      qualCnt <= '0;
    else if (!qualDone)
      qualCnt <= qualCnt + 1'b1;
  end
  assign qualDone = (qualCnt == QW'(QUAL_CYCLES));

  // stabilization delay before reset-done release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stabCnt <= '0;
    else if (!strobe.stabRun)
      stabCnt <= '0;
    else if (!stabDone)
      stabCnt <= stabCnt + 1'b1;
  end
  assign stabDone = (stabCnt == SW'(STAB_CYCLES));

  p_stab_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stabCnt <= SW'(STAB_CYCLES));
endmodule

// File: rtl/rail_seq_control.sv
module rail_seq_control
  import rail_seq_pkg::*;
#(
  parameter int NRAIL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enableN,
  input  logic             sysResetN,
  input  logic [NRAIL-1:0] gateOnDone,
  input  logic [NRAIL-1:0] gateOffDone,
  input  logic             allRailOk,
  input  logic             qualDone,
  input  logic             stabDone,
  output seqStrobe_t       strobe,
  output logic [NRAIL-1:0] gateEn,
  output logic             resetDone
);
  localparam int IW   = (NRAIL > 1) ? $clog2(NRAIL) : 1;
  localparam int LAST = NRAIL - 1;

  seqState_t     state;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
    end else if (!sysResetN) begin
      state <= S_FAULT;
    end else begin
      unique case (state)
        S_IDLE: if (qualDone) begin
          state <= S_UP;
          idx   <= '0;
        end
        S_UP: begin
          if (!allRailOk)            state <= S_FAULT;
          else if (enableN)          state <= S_DOWN;   // release from current gate
          else if (gateOnDone[idx]) begin
            if (idx == IW'(LAST))    state <= S_STAB;
            else                     idx   <= idx + 1'b1;
          end
        end
        S_STAB, S_RUN: begin
          if (!allRailOk) state <= S_FAULT;
          else if (enableN) begin
            state <= S_DOWN;
            idx   <= IW'(LAST);
          end else if (state == S_STAB && stabDone) state <= S_RUN;
        end
        S_DOWN: begin
          if (!allRailOk)              state <= S_FAULT;
          else if (gateOffDone[idx]) begin
            if (idx == '0)             state <= S_IDLE;
            else                       idx   <= idx - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NRAIL; b++) begin
      unique case (state)
        S_UP:          gateEn[b] = (IW'(b) <= idx);
        S_STAB, S_RUN: gateEn[b] = 1'b1;
        S_DOWN:        gateEn[b] = (IW'(b) < idx);
        default:       gateEn[b] = 1'b0;
      endcase
    end
  end

  assign resetDone      = (state == S_RUN);
  assign strobe.qualArm = (state == S_IDLE);
  assign strobe.stabRun = (state == S_STAB);

  // assertions
  p_start_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateEn[0]) |-> $past(qualDone));

  for (genvar k = 1; k < NRAIL; k++) begin : g_onord
    p_on_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gateEn[k]) |-> $past(gateOnDone[k-1]));
  end

  for (genvar k = 0; k < NRAIL - 1; k++) begin : g_offord
    p_off_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gateEn[k]) |-> (!$past(gateEn[k+1]) || gateEn == '0));
  end

  p_off_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DOWN && !gateOffDone[idx] && allRailOk && sysResetN) |=> $stable(gateEn));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetDone) |-> $past(stabDone));

  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!allRailOk && state != S_IDLE) |=> (gateEn == '0 && !resetDone));

  p_sysreset_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sysResetN |=> (gateEn == '0 && !resetDone));
endmodule

// File: rtl/rail_handshake_seq.sv
module rail_handshake_seq
  import rail_seq_pkg::*;
#(
  parameter int NRAIL         = 4,
  parameter int QUAL_CYCLES   = 500000,
  parameter int STAB_CYCLES   = 8000000,
  parameter int GLITCH_CYCLES = 1500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NRAIL-1:0] railGood,
  input  logic             enableN,
  input  logic [NRAIL-1:0] gateOnDone,
  input  logic [NRAIL-1:0] gateOffDone,
  input  logic             sysResetN,
  output logic [NRAIL-1:0] gateEn,
  output logic             resetDone
);
  seqStrobe_t strobe;
  logic allRailOk, qualDone, stabDone;

  rail_seq_datapath #(
    .NRAIL(NRAIL), .QUAL_CYCLES(QUAL_CYCLES),
    .STAB_CYCLES(STAB_CYCLES), .GLITCH_CYCLES(GLITCH_CYCLES)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .railGood(railGood), .enableN(enableN),
    .sysResetN(sysResetN), .strobe(strobe), .allRailOk(allRailOk),
    .qualDone(qualDone), .stabDone(stabDone)
  );

  rail_seq_control #(.NRAIL(NRAIL)) i_ctl (
    .clk(clk), .rst_n(rst_n), .enableN(enableN), .sysResetN(sysResetN),
    .gateOnDone(gateOnDone), .gateOffDone(gateOffDone),
    .allRailOk(allRailOk), .qualDone(qualDone), .stabDone(stabDone),
    .strobe(strobe), .gateEn(gateEn), .resetDone(resetDone)
  );
endmodule

// File: tb/test_rail_handshake_seq.sv
module test_rail_handshake_seq;
  localparam int QUAL   = 40;
  localparam int STAB   = 60;
  localparam int GLITCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] railGood = 4'h0;
  logic enableN = 1'b1;
  logic sysResetN = 1'b1;
  logic autoMode = 1'b0;
  logic [3:0] manOn = 4'h0, manOff = 4'hF;
  logic [3:0] gateOnDone, gateOffDone, gateEn;
  logic resetDone;
  logic [2:0] lvl [0:3];
  logic [3:0] autoOn, autoOff;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  rail_handshake_seq #(.QUAL_CYCLES(QUAL), .STAB_CYCLES(STAB), .GLITCH_CYCLES(GLITCH))
    i_rail_handshake_seq (
      .clk(clk), .rst_n(rst_n), .railGood(railGood), .enableN(enableN),
      .gateOnDone(gateOnDone), .gateOffDone(gateOffDone), .sysResetN(sysResetN),
      .gateEn(gateEn), .resetDone(resetDone));

  // simple gate model: ramps take four cycles each way
  always_ff @(posedge clk) begin
    for (int g = 0; g < 4; g++) begin
      if (!rst_n) lvl[g] <= 3'd0;
      else if (gateEn[g] && lvl[g] != 3'd4) lvl[g] <= lvl[g] + 3'd1;
      else if (!gateEn[g] && lvl[g] != 3'd0) lvl[g] <= lvl[g] - 3'd1;
    end
  end
  always_comb begin
    for (int g = 0; g < 4; g++) begin
      autoOn[g]  = (lvl[g] == 3'd4);
      autoOff[g] = (lvl[g] == 3'd0);
    end
  end
  assign gateOnDone  = autoMode ? autoOn  : manOn;
  assign gateOffDone = autoMode ? autoOff : manOff;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    cyc(3);
    check("R1 gates in reset", gateEn, 4'h0);
    rst_n = 1'b1;
    cyc(5);
    check("R1 gates after reset", gateEn, 4'h0);
    check("R1 resetDone after reset", resetDone, 0);
  endtask

  task automatic t_qualify;
    railGood = 4'hF; enableN = 1'b0;
    cyc(QUAL / 2);
    check("R2 no start before window", gateEn, 4'h0);
    cyc(QUAL / 2 + 10);
    check("R2 gate A after window", gateEn, 4'h1);
  endtask

  task automatic t_handshake;
    cyc(20);
    check("R3 hold without A done", gateEn, 4'h1);
    for (int k = 0; k < 3; k++) begin
      manOn[k] = 1'b1; manOff[k] = 1'b0;
      cyc(3);
      check("R3 next gate after done", gateEn, (2 << k) * 2 - 1);
      manOff[k+1] = 1'b0;
    end
    check("R4 resetDone low before D done", resetDone, 0);
    manOn[3] = 1'b1;
    cyc(STAB / 2);
    check("R4 resetDone low during stab", resetDone, 0);
    cyc(STAB / 2 + 10);
    check("R4 resetDone high after stab", resetDone, 1);
  endtask

  task automatic t_shutdown;
    enableN = 1'b1;
    cyc(2);
    check("R5 resetDone falls", resetDone, 0);
    check("R5 D released first", gateEn, 4'h7);
    cyc(10);
    check("R5 hold without D off", gateEn, 4'h7);
    for (int k = 3; k > 0; k--) begin
      manOn[k] = 1'b0; manOff[k] = 1'b1;
      cyc(3);
      check("R5 next lower released", gateEn, (1 << (k - 1)) - 1);
      cyc(5);
      check("R5 waits for off report", gateEn, (1 << (k - 1)) - 1);
    end
    manOn[0] = 1'b0; manOff[0] = 1'b1;
    cyc(5);
    check("R5 all off and idle", gateEn, 4'h0);
  endtask

  task automatic t_abort;
    manOn = 4'h0; manOff = 4'hF;
    enableN = 1'b0;
    cyc(QUAL + 10);
    check("R6 gate A up", gateEn, 4'h1);
    manOn[0] = 1'b1; manOff = 4'b1100;
    cyc(3);
    check("R6 gate B up", gateEn, 4'h3);
    enableN = 1'b1;
    cyc(3);
    check("R6 B dropped first", gateEn, 4'h1);
    check("R6 resetDone low", resetDone, 0);
    cyc(10);
    check("R6 A waits for B off", gateEn, 4'h1);
    manOff[1] = 1'b1;
    cyc(3);
    check("R6 A released", gateEn, 4'h0);
    manOn = 4'h0; manOff = 4'hF;
    cyc(5);
    check("R6 stays idle", gateEn, 4'h0);
  endtask

  task automatic t_glitch;
    autoMode = 1'b1;
    enableN = 1'b0;
    cyc(200);
    check("R8 auto power-up gates", gateEn, 4'hF);
    check("R8 auto power-up done", resetDone, 1);
    railGood[1] = 1'b0;
    cyc(GLITCH - 3);
    railGood[1] = 1'b1;
    cyc(3);
    check("R7 short dip ignored gates", gateEn, 4'hF);
    check("R7 short dip ignored done", resetDone, 1);
  endtask

  task automatic t_fault;
    railGood[2] = 1'b0;
    cyc(GLITCH + 3);
    check("R8 fault clears gates", gateEn, 4'h0);
    check("R8 fault clears done", resetDone, 0);
    railGood[2] = 1'b1;
    cyc(200);
    check("R8 restart gates", gateEn, 4'hF);
    check("R8 restart done", resetDone, 1);
  endtask

  task automatic t_sysreset;
    sysResetN = 1'b0;
    cyc(2);
    check("R9 latch-off gates", gateEn, 4'h0);
    check("R9 latch-off done", resetDone, 0);
    cyc(50);
    check("R9 held off", gateEn, 4'h0);
    sysResetN = 1'b1;
    cyc(QUAL / 2);
    check("R9 requalify first", gateEn, 4'h0);
    cyc(200);
    check("R9 restart gates", gateEn, 4'hF);
    check("R9 restart done", resetDone, 1);
  endtask

  initial begin
    t_reset();
    t_qualify();
    t_handshake();
    t_shutdown();
    t_abort();
    t_glitch();
    t_fault();
    t_sysreset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule